// File: doc/BRIEF.md
# Interrupt Source Gateway

This block sits between one raw interrupt source and the pending-bit array of an interrupt controller. It turns the source's activity into single requests. After a request has been taken by the pending logic, the gateway sends no further request until a completion pulse arrives for that source. As a result, a source never has more than one request outstanding.

A parameter selects the trigger type. In level mode, the gateway requests whenever the line is high. This applies when the line is first seen high, and again when completion arrives while the line is still high. In edge mode, a rising edge of the registered line causes a request. A one-cycle message strobe has the same effect as an edge. A second parameter decides what happens to edges that arrive while the gateway is busy. Either they are dropped, or they are held in a small saturating counter and replayed one per completion.

Top module: `irq_gateway`

## Requirements
- R1: After reset, `req` is low and the replay counter is zero.
- R2: Once `req` and `req_ack` are both high on a clock edge, `req` stays low until a `done_pulse` has been received.
- R3: `req` stays high from the cycle it rises until a `req_ack` is taken. A level line that drops in the meantime does not withdraw the request.
- R4: Level mode: if the line goes high while idle, `req` rises on the second clock edge after the line is driven.
- R5: Level mode: if the line is still high when `done_pulse` is taken, `req` rises on the next edge. If the line is low, the gateway returns to idle.
- R6: A `done_pulse` taken while idle or while awaiting `req_ack` has no effect.
- R7: Edge mode: a 0-to-1 change of the registered line raises `req` on the second edge after the change is driven. A line held high causes no further request.
- R8: Edge mode with queueing: each edge that arrives while busy adds one to the counter. Each completion then replays one request, and the counter drops by one when that request is accepted.
- R9: The replay counter saturates at 2^CNT_W-1 (15 by default) and does not wrap.
- R10: Edge mode without queueing: edges that arrive while busy are dropped, and completion returns the gateway to idle.
- R11: Edge mode: a one-cycle `msi_strobe` while idle raises `req` on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_line | input | 1 | Raw interrupt line |
| msi_strobe | input | 1 | One-cycle message event, used in edge mode |
| req | output | 1 | Request to the pending-bit array |
| req_ack | input | 1 | Pending logic has taken the request |
| done_pulse | input | 1 | Completion message for this source |

## Verification
The bound checker checks several properties on every cycle: a request is held until it is acknowledged, the request drops after an acknowledge, no request appears while a checker-side copy of the outstanding flag is set, and the counter moves by at most one per cycle. Other behaviour can only be shown by the bench's scenarios. This covers the exact latency from line to request, a replay after completion while the level is still high, the ignored stray completions, the number of replays produced by a burst of edges, saturation after twenty edges, and dropped edges in the variant without a counter.

// File: rtl/irq_gateway.sv
module irq_gateway #(
  parameter bit TRIG_EDGE   = 1'b1,
  parameter bit QUEUE_EDGES = 1'b1,
  parameter int CNT_W       = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_line,
  input  logic msi_strobe,
  output logic req,
  input  logic req_ack,
  input  logic done_pulse
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  typedef enum logic [1:0] {GW_IDLE, GW_WAIT_ACK, GW_WAIT_DONE} gw_state_t;

  gw_state_t        state, state_n;
  logic             line_q, line_d;
  logic             from_cnt, from_cnt_n;
  logic [CNT_W-1:0] edge_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      line_d <= 1'b0;
    end else begin
      line_q <= irq_line;
      line_d <= line_q;
    end
  end

  wire rise     = line_q & ~line_d;
  wire edge_ev  = TRIG_EDGE & (rise | msi_strobe);
  wire level_ev = ~TRIG_EDGE & line_q;
  wire busy     = (state != GW_IDLE);
  wire push     = edge_ev & busy;
  wire pop      = (state == GW_WAIT_ACK) & req_ack & from_cnt;

  generate
    if (TRIG_EDGE && QUEUE_EDGES) begin : g_cnt
      always_ff @(posedge clk) begin
        if (!rst_n)
          edge_cnt <= '0;
        else if (push && !pop && edge_cnt != CNT_MAX)
          edge_cnt <= edge_cnt + 1'b1;
        else if (pop && !push)
          edge_cnt <= edge_cnt - 1'b1;
      end
    end else begin : g_nocnt
      assign edge_cnt = '0;
    end
  endgenerate

  wire replay = TRIG_EDGE ? (QUEUE_EDGES & ((edge_cnt != '0) | edge_ev)) : line_q;

  always_comb begin
    state_n    = state;
    from_cnt_n = from_cnt;
    case (state)
      GW_IDLE:
        if (edge_ev || level_ev) begin
          state_n    = GW_WAIT_ACK;
          from_cnt_n = 1'b0;
        end
      GW_WAIT_ACK:
        if (req_ack) state_n = GW_WAIT_DONE;
      GW_WAIT_DONE:
        if (done_pulse) begin
          state_n    = replay ? GW_WAIT_ACK : GW_IDLE;
          from_cnt_n = replay & TRIG_EDGE;
        end
      default: state_n = GW_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= GW_IDLE;
      from_cnt <= 1'b0;
    end else begin
      state    <= state_n;
      from_cnt <= from_cnt_n;
    end
  end

  assign req = (state == GW_WAIT_ACK);

endmodule

// File: rtl/irq_gateway_chk.sv
module irq_gateway_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req,
  input logic             req_ack,
  input logic             done_pulse,
  input logic [CNT_W-1:0] cnt
);

  logic outstanding;

  always_ff @(posedge clk) begin
    if (!rst_n)                outstanding <= 1'b0;
    else if (req && req_ack)   outstanding <= 1'b1;
    else if (done_pulse)       outstanding <= 1'b0;
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n) outstanding |-> !req); // R2
  AST_ACK_DROPS:       assert property (@(posedge clk) disable iff (!rst_n) (req && req_ack) |=> !req); // R2
  AST_REQ_HOLD:        assert property (@(posedge clk) disable iff (!rst_n) (req && !req_ack) |=> req); // R3
  AST_CNT_STEP:        assert property (@(posedge clk) disable iff (!rst_n)
                         (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1) || (cnt == $past(cnt) - 1'b1)); // R8

endmodule

bind irq_gateway irq_gateway_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .req_ack(req_ack),
  .done_pulse(done_pulse), .cnt(edge_cnt)
);

// File: tb/irq_gateway_tb_top.sv
`timescale 1ns/1ps
module irq_gateway_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [2:0] line = '0, msi = '0, acc = '0, cmp = '0;
  logic [2:0] req;

  irq_gateway #(.TRIG_EDGE(1'b0), .QUEUE_EDGES(1'b1), .CNT_W(4)) dut_lvl_i (
    .clk(clk), .rst_n(rst_n), .irq_line(line[0]), .msi_strobe(msi[0]),
    .req(req[0]), .req_ack(acc[0]), .done_pulse(cmp[0]));
  irq_gateway #(.TRIG_EDGE(1'b1), .QUEUE_EDGES(1'b1), .CNT_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_line(line[1]), .msi_strobe(msi[1]),
    .req(req[1]), .req_ack(acc[1]), .done_pulse(cmp[1]));
  irq_gateway #(.TRIG_EDGE(1'b1), .QUEUE_EDGES(1'b0), .CNT_W(4)) dut_nq_i (
    .clk(clk), .rst_n(rst_n), .irq_line(line[2]), .msi_strobe(msi[2]),
    .req(req[2]), .req_ack(acc[2]), .done_pulse(cmp[2]));

  int nchk = 0, nerr = 0;
  bit finished = 0;
  string exp_q[$];

  task automatic chk(string tag, logic act, logic exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: req=%0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack(int i);
    acc[i] = 1'b1; tick(1); acc[i] = 1'b0;
  endtask

  task automatic done(int i);
    cmp[i] = 1'b1; tick(1); cmp[i] = 1'b0;
  endtask

  task automatic pulse_edge(int i);
    line[i] = 1'b0; tick(1); line[i] = 1'b1; tick(1);
  endtask

  // scoreboard monitor for the queued edge instance
  always @(posedge clk) begin
    if (rst_n && req[1] && acc[1]) begin
      nchk++;
      if (exp_q.size() == 0) begin
        nerr++;
        $display("FAIL R8: unexpected handshake, queued=0 expected >=1");
      end else begin
        void'(exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: run=hung expected=done");
    finish_run();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk("R1 level", req[0], 1'b0);
    chk("R1 edge", req[1], 1'b0);
    chk("R1 noqueue", req[2], 1'b0);

    // level mode
    line[0] = 1'b1; tick(1); chk("R4 early", req[0], 1'b0);
    tick(1); chk("R4 rise", req[0], 1'b1);
    tick(3); chk("R3 hold", req[0], 1'b1);
    ack(0); chk("R2 drop", req[0], 1'b0);
    tick(3); chk("R2 no second", req[0], 1'b0);
    done(0); chk("R5 re-request", req[0], 1'b1);
    line[0] = 1'b0; tick(3); chk("R3 no retract", req[0], 1'b1);
    done(0); chk("R6 stray in wait_ack", req[0], 1'b1);
    ack(0); done(0); tick(2); chk("R5 idle after low", req[0], 1'b0);
    done(0); tick(2); chk("R6 stray in idle", req[0], 1'b0);
    line[0] = 1'b1; tick(2); chk("R6 normal after stray", req[0], 1'b1);
    ack(0); line[0] = 1'b0; done(0); tick(2);

    // edge mode with queue
    line[1] = 1'b1; exp_q.push_back("R7");
    tick(1); chk("R7 early", req[1], 1'b0);
    tick(1); chk("R7 rise", req[1], 1'b1);
    ack(1); done(1); tick(3); chk("R7 held high", req[1], 1'b0);

    pulse_edge(1); exp_q.push_back("R8"); tick(1); chk("R8 first", req[1], 1'b1);
    ack(1); chk("R8 accepted", req[1], 1'b0);
    repeat (3) begin pulse_edge(1); exp_q.push_back("R8"); end
    tick(2); chk("R8 busy", req[1], 1'b0);
    repeat (3) begin done(1); chk("R8 replay", req[1], 1'b1); ack(1); end
    done(1); tick(2); chk("R8 drained", req[1], 1'b0);

    pulse_edge(1); exp_q.push_back("R9"); tick(1); ack(1);
    repeat (20) pulse_edge(1);
    tick(2);
    repeat (15) begin exp_q.push_back("R9"); done(1); chk("R9 replay", req[1], 1'b1); ack(1); end
    done(1); tick(2); chk("R9 saturated", req[1], 1'b0);

    msi[1] = 1'b1; exp_q.push_back("R11"); tick(1); msi[1] = 1'b0;
    chk("R11 msi", req[1], 1'b1);
    ack(1); done(1); tick(2); chk("R11 idle", req[1], 1'b0);

    // edge mode without queue
    line[2] = 1'b1; tick(2); chk("R10 rise", req[2], 1'b1);
    ack(2);
    repeat (3) pulse_edge(2);
    tick(2); done(2); chk("R10 dropped", req[2], 1'b0);
    tick(3); chk("R10 stays idle", req[2], 1'b0);

    tick(2);
    nchk++;
    if (exp_q.size() != 0) begin
      nerr++;
      $display("FAIL R8: missing handshakes=%0d expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule